// File: doc/BRIEF.md
# Debug Client TAP Ownership Gate

This block stands between a JTAG TAP controller that several debug clients share and one debug or trace client. It watches the TAP controller state, the latched instruction and a compliance-enable input. From these it decides when the client is held in reset and when the client owns the TAP.

While the client is in reset, the block does several things:
- It masks the TDI, TMS and TCK inputs the client sees.
- It keeps the client's TDO driver off.
- It drives the client's auxiliary output pads to their idle levels when the client controls those pads.
- It tells the client to empty its message queues. A one-cycle pulse marks each entry into reset, and a level stays high for as long as reset lasts.

Ownership needs two things: an asserted compliance-enable input, and the client's own enable code passing through Update-IR. Ownership is then held until another instruction is updated or the reset condition returns. TDO is enabled only while the owning client is in a shift state.

Top module: `tap_own_gate`

## Requirements
- R1: While `por_n` is low, `client_rst` and `flush_req` are 1, and `owner`, `flush_pulse` and `tdo_oe` are 0.
- R2: On each clock edge, `client_rst` takes the value of (`tap_state` is Test-Logic-Reset, code 4'h0) OR (`comply_en` is 0).
- R3: An edge with `tap_state` at Update-IR (code 4'hF), `ir_value` equal to `ENABLE_CODE` (default 4'hA) and `comply_en` at 1 sets `owner` to 1.
- R4: `owner` keeps its value in every state except Update-IR. An edge at Update-IR with any other `ir_value` clears `owner`.
- R5: An edge with the reset condition of R2 present clears `owner`, and no code can set it on that edge.
- R6: `tdo_oe` is 1 exactly when all of the following hold: `owner` is 1, `client_rst` is 0, `comply_en` is 1, and `tap_state` is Shift-DR (4'h4) or Shift-IR (4'hB). It follows its inputs within the same cycle.
- R7: `client_tdi`, `client_tms` and `client_tck` equal `tdi`, `tms` and `tck` while `client_rst` is 0, and are 0 while `client_rst` is 1.
- R8: While `client_rst` and `pad_own` are both 1, `aux_out` equals `AUX_IDLE` (default 4'b1100). In every other case `aux_out` equals `aux_in`.
- R9: `flush_req` equals `client_rst`.
- R10: `flush_pulse` is 1 for exactly the first cycle in which `client_rst` is 1 after having been 0. It stays 0 across the release of power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| comply_en | input | 1 | Compliance enable; must be 1 for the client to leave reset |
| tap_state | input | 4 | Current TAP controller state code |
| ir_value | input | IR_W | Latched TAP instruction |
| tdi | input | 1 | Test data in from the pad |
| tms | input | 1 | Test mode select from the pad |
| tck | input | 1 | Test clock from the pad |
| pad_own | input | 1 | Client currently controls the auxiliary pads |
| aux_in | input | AUX_W | Auxiliary port values from the client |
| client_rst | output | 1 | Client held in reset |
| owner | output | 1 | Client owns the TAP |
| tdo_oe | output | 1 | TDO output buffer enable |
| client_tdi | output | 1 | Gated TDI to the client |
| client_tms | output | 1 | Gated TMS to the client |
| client_tck | output | 1 | Gated TCK to the client |
| aux_out | output | AUX_W | Auxiliary pad values |
| flush_req | output | 1 | Queue flush level, held during reset |
| flush_pulse | output | 1 | One-cycle queue flush on reset entry |

## Verification
The assertions check on every cycle that:
- reset follows the previous cycle's reset condition;
- ownership is dropped whenever that condition was present;
- ownership is taken after a matching Update-IR;
- TDO is never enabled outside an owned shift;
- the gated JTAG inputs are quiet during reset;
- the flush pulse lasts one cycle and occurs only inside reset.

Only the bench scenarios can show the rest:
- that ownership survives other states and is lost on a foreign code;
- that pads fall back to their idle pattern only when the client controls them;
- that power-on release gives no flush pulse;
- the exact value sequence across a loss of compliance-enable while shifting.

// File: rtl/tapgate_pkg.sv
package tapgate_pkg;

    typedef enum logic [3:0] {
        TS_RESET    = 4'h0,
        TS_IDLE     = 4'h1,
        TS_SEL_DR   = 4'h2,
        TS_CAP_DR   = 4'h3,
        TS_SHIFT_DR = 4'h4,
        TS_EX1_DR   = 4'h5,
        TS_PAUSE_DR = 4'h6,
        TS_EX2_DR   = 4'h7,
        TS_UPD_DR   = 4'h8,
        TS_SEL_IR   = 4'h9,
        TS_CAP_IR   = 4'hA,
        TS_SHIFT_IR = 4'hB,
        TS_EX1_IR   = 4'hC,
        TS_PAUSE_IR = 4'hD,
        TS_EX2_IR   = 4'hE,
        TS_UPD_IR   = 4'hF
    } tap_state_e;

    typedef struct packed {
        logic client_rst;
        logic owner;
        logic flush_pulse;
    } gate_regs_t;

    localparam gate_regs_t GATE_RESET = '{client_rst: 1'b1, owner: 1'b0, flush_pulse: 1'b0};

    function automatic logic is_shift(tap_state_e s);
        return (s == TS_SHIFT_DR) || (s == TS_SHIFT_IR);
    endfunction

endpackage

// File: rtl/tapgate_decode.sv
module tapgate_decode
    import tapgate_pkg::*;
#(
    parameter int unsigned IR_W        = 4,
    parameter int unsigned ENABLE_CODE = 'hA
) (
    input  logic [3:0]      tap_state,
    input  logic [IR_W-1:0] ir_value,
    input  logic            comply_en,
    output logic            rst_cond,
    output logic            in_upd_ir,
    output logic            in_shift,
    output logic            code_match
);
    localparam logic [IR_W-1:0] OWN_CODE = IR_W'(ENABLE_CODE);

    tap_state_e state;

    always_comb begin
        state      = tap_state_e'(tap_state);
        rst_cond   = (state == TS_RESET) || !comply_en;
        in_upd_ir  = (state == TS_UPD_IR);
        in_shift   = is_shift(state);
        code_match = (ir_value == OWN_CODE);
    end
endmodule

// File: rtl/tapgate_ctrl.sv
module tapgate_ctrl
    import tapgate_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_cond,
    input  logic in_upd_ir,
    input  logic code_match,
    output logic client_rst,
    output logic owner,
    output logic flush_pulse
);
    gate_regs_t regs_d, regs_q;

    always_comb begin
        regs_d             = regs_q;
        regs_d.flush_pulse = 1'b0;
        if (rst_cond) begin
            regs_d.client_rst  = 1'b1;
            regs_d.owner       = 1'b0;
            regs_d.flush_pulse = !regs_q.client_rst;
        end else begin
            regs_d.client_rst = 1'b0;
            if (in_upd_ir) begin
                regs_d.owner = code_match;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            regs_q <= GATE_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign client_rst  = regs_q.client_rst;
    assign owner       = regs_q.owner;
    assign flush_pulse = regs_q.flush_pulse;
endmodule

// File: rtl/tapgate_pins.sv
module tapgate_pins #(
    parameter int unsigned      AUX_W    = 4,
    parameter logic [AUX_W-1:0] AUX_IDLE = AUX_W'(12)
) (
    input  logic             client_rst,
    input  logic             owner,
    input  logic             comply_en,
    input  logic             in_shift,
    input  logic             tdi,
    input  logic             tms,
    input  logic             tck,
    input  logic             pad_own,
    input  logic [AUX_W-1:0] aux_in,
    output logic             tdo_oe,
    output logic             client_tdi,
    output logic             client_tms,
    output logic             client_tck,
    output logic [AUX_W-1:0] aux_out
);
    logic live;
    logic force_idle;

    assign live       = !client_rst;
    assign force_idle = client_rst && pad_own;

    assign tdo_oe     = owner && live && comply_en && in_shift;
    assign client_tdi = tdi && live;
    assign client_tms = tms && live;
    assign client_tck = tck && live;

    for (genvar i = 0; i < AUX_W; i++) begin : g_aux
        assign aux_out[i] = force_idle ? AUX_IDLE[i] : aux_in[i];
    end
endmodule

// File: rtl/tap_own_gate.sv
module tap_own_gate #(
    parameter int unsigned      IR_W        = 4,
    parameter int unsigned      ENABLE_CODE = 'hA,
    parameter int unsigned      AUX_W       = 4,
    parameter logic [AUX_W-1:0] AUX_IDLE    = AUX_W'(12)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             comply_en,
    input  logic [3:0]       tap_state,
    input  logic [IR_W-1:0]  ir_value,
    input  logic             tdi,
    input  logic             tms,
    input  logic             tck,
    input  logic             pad_own,
    input  logic [AUX_W-1:0] aux_in,
    output logic             client_rst,
    output logic             owner,
    output logic             tdo_oe,
    output logic             client_tdi,
    output logic             client_tms,
    output logic             client_tck,
    output logic [AUX_W-1:0] aux_out,
    output logic             flush_req,
    output logic             flush_pulse
);
    logic rst_cond, in_upd_ir, in_shift, code_match;

    tapgate_decode #(.IR_W(IR_W), .ENABLE_CODE(ENABLE_CODE)) decode_i (
        .tap_state  (tap_state),
        .ir_value   (ir_value),
        .comply_en  (comply_en),
        .rst_cond   (rst_cond),
        .in_upd_ir  (in_upd_ir),
        .in_shift   (in_shift),
        .code_match (code_match)
    );

    tapgate_ctrl ctrl_i (
        .clk         (clk),
        .por_n       (por_n),
        .rst_cond    (rst_cond),
        .in_upd_ir   (in_upd_ir),
        .code_match  (code_match),
        .client_rst  (client_rst),
        .owner       (owner),
        .flush_pulse (flush_pulse)
    );

    tapgate_pins #(.AUX_W(AUX_W), .AUX_IDLE(AUX_IDLE)) pins_i (
        .client_rst (client_rst),
        .owner      (owner),
        .comply_en  (comply_en),
        .in_shift   (in_shift),
        .tdi        (tdi),
        .tms        (tms),
        .tck        (tck),
        .pad_own    (pad_own),
        .aux_in     (aux_in),
        .tdo_oe     (tdo_oe),
        .client_tdi (client_tdi),
        .client_tms (client_tms),
        .client_tck (client_tck),
        .aux_out    (aux_out)
    );

    assign flush_req = client_rst;
endmodule

// File: rtl/tap_own_gate_chk.sv
module tap_own_gate_chk #(
    parameter int unsigned IR_W        = 4,
    parameter int unsigned ENABLE_CODE = 'hA
) (
    input logic            clk,
    input logic            por_n,
    input logic            comply_en,
    input logic [3:0]      tap_state,
    input logic [IR_W-1:0] ir_value,
    input logic            client_rst,
    input logic            owner,
    input logic            tdo_oe,
    input logic            client_tdi,
    input logic            client_tms,
    input logic            client_tck,
    input logic            flush_pulse
);
    assert_rst_follows_R2: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (client_rst == $past((tap_state == 4'h0) || !comply_en)));

    assert_grant_R3: assert property (@(posedge clk) disable iff (!por_n)
        ((tap_state == 4'hF) && (ir_value == IR_W'(ENABLE_CODE)) && comply_en) |=> owner);

    assert_drop_R5: assert property (@(posedge clk) disable iff (!por_n)
        ((tap_state == 4'h0) || !comply_en) |=> !owner);

    assert_tdo_owned_R6: assert property (@(posedge clk) disable iff (!por_n)
        tdo_oe |-> (owner && !client_rst && ((tap_state == 4'h4) || (tap_state == 4'hB))));

    assert_inputs_masked_R7: assert property (@(posedge clk) disable iff (!por_n)
        client_rst |-> (!client_tdi && !client_tms && !client_tck));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!por_n)
        flush_pulse |=> !flush_pulse);

    assert_pulse_in_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        flush_pulse |-> client_rst);
endmodule

bind tap_own_gate tap_own_gate_chk #(.IR_W(IR_W), .ENABLE_CODE(ENABLE_CODE)) chk_i (
    .clk         (clk),
    .por_n       (por_n),
    .comply_en   (comply_en),
    .tap_state   (tap_state),
    .ir_value    (ir_value),
    .client_rst  (client_rst),
    .owner       (owner),
    .tdo_oe      (tdo_oe),
    .client_tdi  (client_tdi),
    .client_tms  (client_tms),
    .client_tck  (client_tck),
    .flush_pulse (flush_pulse)
);

// File: tb/tap_own_gate_tb_top.sv
`timescale 1ns/1ps
module tap_own_gate_tb_top;
    logic       clk = 1'b0;
    logic       por_n, comply_en, tdi, tms, tck, pad_own;
    logic [3:0] tap_state, ir_value, aux_in;
    logic       client_rst, owner, tdo_oe, client_tdi, client_tms, client_tck;
    logic [3:0] aux_out;
    logic       flush_req, flush_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tap_own_gate dut_i (
        .clk(clk), .por_n(por_n), .comply_en(comply_en), .tap_state(tap_state),
        .ir_value(ir_value), .tdi(tdi), .tms(tms), .tck(tck), .pad_own(pad_own),
        .aux_in(aux_in), .client_rst(client_rst), .owner(owner), .tdo_oe(tdo_oe),
        .client_tdi(client_tdi), .client_tms(client_tms), .client_tck(client_tck),
        .aux_out(aux_out), .flush_req(flush_req), .flush_pulse(flush_pulse)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_power_on();
        por_n = 1'b0; comply_en = 1'b0; tap_state = 4'h0; ir_value = 4'h0;
        tdi = 1'b0; tms = 1'b0; tck = 1'b0; pad_own = 1'b0; aux_in = 4'h0;
        tick(); tick();
        chk("R1 client_rst", client_rst, 1);
        chk("R1 owner", owner, 0);
        chk("R1 flush_pulse", flush_pulse, 0);
        chk("R1 tdo_oe", tdo_oe, 0);
        chk("R9 flush_req", flush_req, 1);
        por_n = 1'b1;
        tick();
        chk("R10 no pulse on por release", flush_pulse, 0);
        chk("R2 still reset in TLR", client_rst, 1);
    endtask

    task automatic t_leave_reset();
        comply_en = 1'b1; tap_state = 4'h1;
        tick();
        chk("R2 leaves reset", client_rst, 0);
        chk("R9 flush_req low", flush_req, 0);
        chk("R10 no pulse on exit", flush_pulse, 0);
    endtask

    task automatic t_grant_and_shift();
        tap_state = 4'hF; ir_value = 4'hA;
        tick();
        chk("R3 owner after enable code", owner, 1);
        tap_state = 4'h4; settle();
        chk("R6 tdo_oe in Shift-DR", tdo_oe, 1);
        tap_state = 4'h6; settle();
        chk("R6 tdo_oe off in Pause-DR", tdo_oe, 0);
        tap_state = 4'hB; settle();
        chk("R6 tdo_oe in Shift-IR", tdo_oe, 1);
        tap_state = 4'h1; ir_value = 4'h3;
        tick(); tick();
        chk("R4 owner held outside Update-IR", owner, 1);
    endtask

    task automatic t_foreign_code();
        tap_state = 4'hF; ir_value = 4'h3;
        tick();
        chk("R4 owner cleared by other code", owner, 0);
        tap_state = 4'h4; settle();
        chk("R6 tdo_oe off without ownership", tdo_oe, 0);
    endtask

    task automatic t_pass_through();
        tap_state = 4'h1; tdi = 1'b1; tms = 1'b1; tck = 1'b1;
        pad_own = 1'b1; aux_in = 4'h5; settle();
        chk("R7 tdi passes", client_tdi, 1);
        chk("R7 tms passes", client_tms, 1);
        chk("R7 tck passes", client_tck, 1);
        chk("R8 aux passes out of reset", aux_out, 4'h5);
    endtask

    task automatic t_tap_reset();
        tap_state = 4'hF; ir_value = 4'hA;
        tick();
        chk("R3 regrant", owner, 1);
        tap_state = 4'h0;
        tick();
        chk("R2 reset on TLR", client_rst, 1);
        chk("R5 owner dropped", owner, 0);
        chk("R10 pulse on entry", flush_pulse, 1);
        chk("R7 tdi masked", client_tdi, 0);
        chk("R7 tms masked", client_tms, 0);
        chk("R7 tck masked", client_tck, 0);
        chk("R8 aux idle with pad_own", aux_out, 4'hC);
        pad_own = 1'b0; settle();
        chk("R8 aux passes without pad_own", aux_out, 4'h5);
        tick();
        chk("R10 pulse one cycle", flush_pulse, 0);
        chk("R9 flush_req held", flush_req, 1);
    endtask

    task automatic t_comply_gate();
        comply_en = 1'b0; tap_state = 4'hF; ir_value = 4'hA;
        tick();
        chk("R3 no grant without comply_en", owner, 0);
        chk("R2 reset without comply_en", client_rst, 1);
        comply_en = 1'b1;
        tick();
        chk("R3 grant once comply_en returns", owner, 1);
        chk("R2 out of reset", client_rst, 0);
        tap_state = 4'h4; settle();
        chk("R6 tdo_oe before drop", tdo_oe, 1);
        comply_en = 1'b0; settle();
        chk("R6 tdo_oe off at once on comply drop", tdo_oe, 0);
        tick();
        chk("R5 owner dropped on comply loss", owner, 0);
        chk("R10 pulse on comply loss", flush_pulse, 1);
        chk("R2 reset on comply loss", client_rst, 1);
    endtask

    initial begin
        t_power_on();
        t_leave_reset();
        t_grant_and_shift();
        t_foreign_code();
        t_pass_through();
        t_tap_reset();
        t_comply_gate();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule